// File: doc/BRIEF.md
# Byte Load/Store Unit for Word-Addressed Memory

This unit runs byte-load and byte-store instructions against a memory that can only be read and written as whole 16-bit words. A request carries the instruction word, the byte pointer taken from the pointer accumulator, and the low byte of the data accumulator. The unit checks that the word really is a byte instruction. It turns the pointer into a word address and a byte select, reads the word, and for a store writes the merged word back. It then returns a result for the destination accumulator.

Requests and responses are valid/ready streams. A request is taken on a rising edge where `req_valid` and `req_ready` are both high. `req_ready` is high only while the unit is idle, or while it holds a response that is being taken in that same cycle. A response stays valid, and all its fields stay unchanged, until `rsp_ready` is seen high. The instruction fields that name accumulators are decoded without delay onto `ptr_acc` and `data_acc`, so the surrounding register file can present the right operands alongside the request. The memory port has a single cycle of read latency: `mem_rdata` is valid in the cycle after the cycle in which `mem_rd` is high.

Top module: `byte_ls_unit`

## Requirements
- R1: An instruction is legal only if bits 15:13 are 011, bits 5:0 are 000001 and bits 10:8 are 001 (load) or 100 (store). Any other word gives a response with `rsp_illegal`=1, `rsp_wen`=0 and `rsp_data`=0, and issues no memory read or write.
- R2: `ptr_acc` equals `req_insn[7:6]` and `data_acc` equals `req_insn[12:11]` in the same cycle, without a register.
- R3: The word address is the pointer shifted right by one with a 0 in bit 15. `mem_rd` is high with this address in the cycle after acceptance.
- R4: Pointer bit 0 picks the byte. A value of 0 selects bits 15:8 and a value of 1 selects bits 7:0.
- R5: A load responds with the selected byte in `rsp_data[7:0]` and zeros in bits 15:8. It sets `rsp_wen`=1, and `rsp_acd` equals instruction bits 12:11.
- R6: A store raises `mem_wr` at the same address in the cycle after the read. It writes the read word with only the selected byte replaced by `req_data`, and the other byte is unchanged. The response carries this word, with `rsp_wen`=0.
- R7: For every request, `rsp_valid` first rises in the third cycle after the acceptance edge, that is, after two further rising edges.
- R8: While `rsp_valid` is high and `rsp_ready` is low, the response fields hold steady and `req_ready` is low.
- R9: `done` is high for exactly one cycle, the first cycle of each response.
- R10: When a response is taken, a new request can be accepted in the same cycle. Its read then starts in the next cycle.
- R11: During reset and right after it, `rsp_valid`, `done`, `mem_rd` and `mem_wr` are 0 and `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_insn | input | 16 | Instruction word |
| req_ptr | input | 16 | Byte pointer value |
| req_data | input | 8 | Low byte of the data accumulator (store data) |
| ptr_acc | output | 2 | Index of the pointer accumulator, decoded from req_insn |
| data_acc | output | 2 | Index of the data/destination accumulator, decoded from req_insn |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response consumer ready |
| rsp_data | output | 16 | Loaded byte (zero-extended) or stored word |
| rsp_acd | output | 2 | Destination accumulator index |
| rsp_wen | output | 1 | Destination accumulator must be written |
| rsp_illegal | output | 1 | Request was not a legal byte instruction |
| done | output | 1 | One-cycle strobe at the start of each response |
| mem_rd | output | 1 | Word read strobe |
| mem_wr | output | 1 | Word write strobe |
| mem_addr | output | 16 | Word address |
| mem_wdata | output | 16 | Merged write word |
| mem_rdata | input | 16 | Read word, valid one cycle after mem_rd |

## Verification
Two functions can land in the same cycle: the retirement of a pending response and the acceptance of the next request. The bench provokes this by holding `rsp_ready` low so that a load response is stalled. It then raises `rsp_ready` and presents a store in the same cycle. The test passes if `req_ready` goes high at once, the stalled response holds unchanged until that edge, and the store's read follows on the next cycle with the correct merged write after it.

// File: rtl/blsu_pkg.sv
package blsu_pkg;
  localparam int INSN_W = 16;
  localparam logic [2:0] OPC_IO   = 3'b011;
  localparam logic [5:0] DEV_BYTE = 6'b000001;
  localparam logic [2:0] XF_LOAD  = 3'b001;
  localparam logic [2:0] XF_STORE = 3'b100;

  typedef enum logic [1:0] {ST_IDLE, ST_READ, ST_XFER, ST_RESP} blsu_state_e;
  typedef enum logic [1:0] {OP_NONE, OP_LOAD, OP_STORE} blsu_op_e;

  typedef struct packed {
    blsu_op_e   op;
    logic [1:0] acd;
    logic [1:0] acs;
  } blsu_dec_t;
endpackage

// File: rtl/blsu_decode.sv
module blsu_decode
  import blsu_pkg::*;
(
  input  logic [INSN_W-1:0] insn,
  output blsu_dec_t         dec
);
  logic [2:0] opc_f;
  logic [2:0] xfer_f;
  logic [5:0] dev_f;
  logic       frame_ok;

  always_comb begin
    opc_f    = insn[15:13];
    xfer_f   = insn[10:8];
    dev_f    = insn[5:0];
    frame_ok = (opc_f == OPC_IO) && (dev_f == DEV_BYTE);
    dec.acd  = insn[12:11];
    dec.acs  = insn[7:6];
    if (frame_ok && xfer_f == XF_LOAD)       dec.op = OP_LOAD;
    else if (frame_ok && xfer_f == XF_STORE) dec.op = OP_STORE;
    else                                     dec.op = OP_NONE;
  end
endmodule

// File: rtl/blsu_lane.sv
module blsu_lane #(
  parameter int WORD_W = 16
) (
  input  logic [WORD_W-1:0]   rword,
  input  logic [WORD_W/2-1:0] src,
  input  logic                sel,
  output logic [WORD_W-1:0]   load_val,
  output logic [WORD_W-1:0]   merged
);
  localparam int BYTE_W = WORD_W / 2;
  localparam int LANES  = 2;

  logic [BYTE_W-1:0] lane_byte [LANES];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    // lane 0 is the high-order byte, selected by sel == 0
    localparam int TOP = WORD_W - 1 - g * BYTE_W;
    assign lane_byte[g] = rword[TOP -: BYTE_W];
    assign merged[TOP -: BYTE_W] = (int'(sel) == g) ? src : rword[TOP -: BYTE_W];
  end

  assign load_val = {{BYTE_W{1'b0}}, lane_byte[sel]};
endmodule

// File: rtl/blsu_ctrl.sv
module blsu_ctrl
  import blsu_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic rsp_ready,
  output logic req_ready,
  output logic accept,
  output logic in_read,
  output logic in_xfer,
  output logic rsp_valid,
  output logic done
);
  blsu_state_e state_q, state_d;
  logic        done_q;

  always_comb begin
    req_ready = (state_q == ST_IDLE) || (state_q == ST_RESP && rsp_ready);
    accept    = req_valid && req_ready;
    state_d   = state_q;
    case (state_q)
      ST_IDLE: if (accept) state_d = ST_READ;
      ST_READ: state_d = ST_XFER;
      ST_XFER: state_d = ST_RESP;
      ST_RESP: if (rsp_ready) state_d = accept ? ST_READ : ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= (state_q == ST_XFER);
    end
  end

  assign in_read   = (state_q == ST_READ);
  assign in_xfer   = (state_q == ST_XFER);
  assign rsp_valid = (state_q == ST_RESP);
  assign done      = done_q;

  // R9
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7
  rsp_rise_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_valid) |-> done);

  // R8
  busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready);
endmodule

// File: rtl/byte_ls_unit.sv
module byte_ls_unit
  import blsu_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [INSN_W-1:0]   req_insn,
  input  logic [WORD_W-1:0]   req_ptr,
  input  logic [WORD_W/2-1:0] req_data,
  output logic [1:0]          ptr_acc,
  output logic [1:0]          data_acc,
  output logic                rsp_valid,
  input  logic                rsp_ready,
  output logic [WORD_W-1:0]   rsp_data,
  output logic [1:0]          rsp_acd,
  output logic                rsp_wen,
  output logic                rsp_illegal,
  output logic                done,
  output logic                mem_rd,
  output logic                mem_wr,
  output logic [WORD_W-1:0]   mem_addr,
  output logic [WORD_W-1:0]   mem_wdata,
  input  logic [WORD_W-1:0]   mem_rdata
);
  localparam int BYTE_W = WORD_W / 2;

  blsu_dec_t         dec;
  blsu_op_e          op_q;
  logic [1:0]        acd_q;
  logic [WORD_W-1:0] ptr_q;
  logic [BYTE_W-1:0] data_q;
  logic              accept, in_read, in_xfer;
  logic [WORD_W-1:0] load_val, merged;
  logic [WORD_W-1:0] rsp_data_q;
  logic [1:0]        rsp_acd_q;
  logic              rsp_wen_q, rsp_ill_q;

  blsu_decode u_dec (
    .insn (req_insn),
    .dec  (dec)
  );

  blsu_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .rsp_ready (rsp_ready),
    .req_ready (req_ready),
    .accept    (accept),
    .in_read   (in_read),
    .in_xfer   (in_xfer),
    .rsp_valid (rsp_valid),
    .done      (done)
  );

  blsu_lane #(.WORD_W(WORD_W)) u_lane (
    .rword    (mem_rdata),
    .src      (data_q),
    .sel      (ptr_q[0]),
    .load_val (load_val),
    .merged   (merged)
  );

  assign ptr_acc  = dec.acs;
  assign data_acc = dec.acd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q   <= OP_NONE;
      acd_q  <= '0;
      ptr_q  <= '0;
      data_q <= '0;
    end else if (accept) begin
      op_q   <= dec.op;
      acd_q  <= dec.acd;
      ptr_q  <= req_ptr;
      data_q <= req_data;
    end
  end

  assign mem_addr  = {1'b0, ptr_q[WORD_W-1:1]};
  assign mem_rd    = in_read && (op_q != OP_NONE);
  assign mem_wr    = in_xfer && (op_q == OP_STORE);
  assign mem_wdata = merged;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_data_q <= '0;
      rsp_acd_q  <= '0;
      rsp_wen_q  <= 1'b0;
      rsp_ill_q  <= 1'b0;
    end else if (in_xfer) begin
      case (op_q)
        OP_LOAD:  rsp_data_q <= load_val;
        OP_STORE: rsp_data_q <= merged;
        default:  rsp_data_q <= '0;
      endcase
      rsp_acd_q <= acd_q;
      rsp_wen_q <= (op_q == OP_LOAD);
      rsp_ill_q <= (op_q == OP_NONE);
    end
  end

  assign rsp_data    = rsp_data_q;
  assign rsp_acd     = rsp_acd_q;
  assign rsp_wen     = rsp_wen_q;
  assign rsp_illegal = rsp_ill_q;

  // R6
  wr_follows_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> ($past(mem_rd) && $stable(mem_addr)));

  // R3
  addr_top_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |-> !mem_addr[WORD_W-1]);

  // R8
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data) &&
                                   $stable(rsp_wen) && $stable(rsp_illegal)));

  // R5
  load_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_wen) |-> (rsp_data[WORD_W-1:BYTE_W] == '0));

  // R1
  illegal_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_illegal) |-> (!rsp_wen && rsp_data == '0));
endmodule

// File: tb/byte_ls_unit_test.sv
module byte_ls_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [15:0] req_insn = '0;
  logic [15:0] req_ptr = '0;
  logic [7:0]  req_data = '0;
  logic [1:0]  ptr_acc, data_acc;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [15:0] rsp_data;
  logic [1:0]  rsp_acd;
  logic        rsp_wen, rsp_illegal, done;
  logic        mem_rd, mem_wr;
  logic [15:0] mem_addr, mem_wdata;
  logic [15:0] mem_rdata = '0;
  logic [15:0] mem [16];

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  byte_ls_unit uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_insn(req_insn), .req_ptr(req_ptr), .req_data(req_data),
    .ptr_acc(ptr_acc), .data_acc(data_acc), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_data(rsp_data), .rsp_acd(rsp_acd),
    .rsp_wen(rsp_wen), .rsp_illegal(rsp_illegal), .done(done),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  always @(posedge clk) begin
    if (mem_wr) mem[mem_addr[3:0]] <= mem_wdata;
    if (mem_rd) mem_rdata <= mem[mem_addr[3:0]];
  end

  // {illegal, wen, insn, ptr, data, expected}
  localparam logic [57:0] VECS [13] = '{
    {1'b0, 1'b1, 16'h7141, 16'h0006, 8'h00, 16'h00A3},
    {1'b0, 1'b1, 16'h7141, 16'h0007, 8'h00, 16'h0053},
    {1'b0, 1'b0, 16'h6CC1, 16'h0008, 8'hEE, 16'hEE54},
    {1'b0, 1'b1, 16'h6101, 16'h0008, 8'h00, 16'h00EE},
    {1'b0, 1'b1, 16'h6101, 16'h0009, 8'h00, 16'h0054},
    {1'b0, 1'b0, 16'h7C81, 16'h000B, 8'h77, 16'hA577},
    {1'b0, 1'b1, 16'h6101, 16'h000A, 8'h00, 16'h00A5},
    {1'b0, 1'b1, 16'h6101, 16'h000B, 8'h00, 16'h0077},
    {1'b1, 1'b0, 16'h6201, 16'h000A, 8'h00, 16'h0000},
    {1'b1, 1'b0, 16'h6102, 16'h000A, 8'h00, 16'h0000},
    {1'b1, 1'b0, 16'h4101, 16'h000A, 8'h00, 16'h0000},
    {1'b0, 1'b1, 16'h6101, 16'h001F, 8'h00, 16'h005F},
    {1'b0, 1'b1, 16'h6101, 16'hFFFE, 8'h00, 16'h00AF}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_vec(input logic ill, input logic wen, input logic [15:0] insn,
                         input logic [15:0] ptr, input logic [7:0] data,
                         input logic [15:0] exp);
    logic st;
    st = !ill && (insn[10:8] == 3'b100);
    @(negedge clk);
    req_insn = insn; req_ptr = ptr; req_data = data; req_valid = 1'b1;
    #1;
    chk("R8 req_ready idle", req_ready, 1);
    chk("R2 ptr_acc", ptr_acc, insn[7:6]);
    chk("R2 data_acc", data_acc, insn[12:11]);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R1/R3 mem_rd", mem_rd, !ill);
    if (!ill) chk("R3 word address", mem_addr, {1'b0, ptr[15:1]});
    @(negedge clk);
    chk("R7 no early response", rsp_valid, 0);
    chk("R1/R6 mem_wr", mem_wr, st);
    if (st) begin
      chk("R6 write address", mem_addr, {1'b0, ptr[15:1]});
      chk("R6 merged word R4", mem_wdata, exp);
    end
    if (ill) chk("R1 no memory read", mem_rd, 0);
    @(negedge clk);
    chk("R7 rsp_valid", rsp_valid, 1);
    chk("R9 done first cycle", done, 1);
    chk("R5/R6 rsp_data R4", rsp_data, exp);
    chk("R5 rsp_wen", rsp_wen, wen);
    chk("R1 rsp_illegal", rsp_illegal, ill);
    if (!ill) chk("R5 rsp_acd", rsp_acd, insn[12:11]);
    @(negedge clk);
    chk("R9 done cleared", done, 0);
    chk("R8 response retired", rsp_valid, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) mem[i] = {4'hA, 4'(i), 4'h5, 4'(i)};
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 rsp_valid", rsp_valid, 0);
    chk("R11 done", done, 0);
    chk("R11 mem strobes", {mem_rd, mem_wr}, 0);
    chk("R11 req_ready", req_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 idle after reset", {rsp_valid, done, mem_rd, mem_wr}, 0);

    for (int v = 0; v < 13; v++)
      run_vec(VECS[v][57], VECS[v][56], VECS[v][55:40], VECS[v][39:24],
              VECS[v][23:16], VECS[v][15:0]);
    chk("R6 other byte kept in memory", mem[5], 16'hA577);

    // R8/R10 stalled load followed by a store accepted in the retire cycle
    @(negedge clk);
    rsp_ready = 1'b0;
    req_insn = 16'h7141; req_ptr = 16'h0006; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk("R7 stalled load valid", rsp_valid, 1);
    chk("R9 stalled load done", done, 1);
    chk("R5 stalled load data", rsp_data, 16'h00A3);
    @(negedge clk);
    chk("R8 held valid", rsp_valid, 1);
    chk("R8 held data", rsp_data, 16'h00A3);
    chk("R9 no second done", done, 0);
    chk("R8 req_ready low", req_ready, 0);
    rsp_ready = 1'b1;
    req_insn = 16'h6CC1; req_ptr = 16'h0006; req_data = 8'h5A; req_valid = 1'b1;
    #1;
    chk("R10 ready in retire cycle", req_ready, 1);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R10 response gone", rsp_valid, 0);
    chk("R10 read started", mem_rd, 1);
    chk("R10 read address", mem_addr, 16'h0003);
    @(negedge clk);
    chk("R6 write strobe", mem_wr, 1);
    chk("R6 write word", mem_wdata, 16'h5A53);
    @(negedge clk);
    chk("R9 store done", done, 1);
    chk("R6 store rsp", rsp_data, 16'h5A53);
    run_vec(1'b0, 1'b1, 16'h6101, 16'h0006, 8'h00, 16'h005A);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule